// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

The block holds three independent 16-bit down counters behind a narrow byte-wide register port. Software reaches the count register of counter 0, 1 or 2 at addresses 0, 1 and 2. A control byte written at address 3 picks one counter and sets four things: how its 16-bit value is moved through the 8-bit port, its counting mode, and whether it counts in binary or in four-digit BCD. Every counter decrements on a shared clock enable (`tick`) and drives one output pin.

A full 16-bit value goes through the port one byte at a time. Each counter keeps a byte pointer for this. A latch command freezes a snapshot of the running count, so that both bytes of one consistent value can be read while the counter keeps running. Three counting modes are implemented: terminal-count flag (mode 0), rate generator (mode 2) and square wave (mode 3). The bus is a plain register port with single-cycle write and read strobes. It has no stream data path and no back-pressure: a strobe is always accepted in the cycle it is sampled, and read data is valid combinationally in the same cycle as `bus_rd`.

Top module: `interval_timer_trio`

## Requirements
- R1: After reset every output is high. Each counter holds 0 and uses low-byte-only access, so a read of address 0 returns 8'h00.
- R2: In a control byte (address 3), bits 7:6 pick the counter (0, 1, 2). A value of 3 in these bits makes the whole byte ignored. Bits 5:4 give the access code: 0 latch, 1 low byte only, 2 high byte only, 3 low then high. Bits 3:1 give the mode, where codes 6 and 7 act as modes 2 and 3. Bit 0 = 1 selects BCD.
- R3: With access code 1, a write loads {8'h00, byte}. With code 2, it loads {byte, 8'h00}. With code 3, the first write is the low byte and the second is the high byte. The byte pointer toggles on every port read or write in code 3, and any non-latch control byte to that counter resets it to low.
- R4: A latch command copies the current count into a hold register. Reads then return the held value until all bytes of it have been read (two bytes for access code 3, otherwise one). A latch command that arrives while a snapshot is still unread is ignored.
- R5: With no latch pending, a read returns the live count. Reads never change the count or its progress.
- R6: A completed count write takes effect on the first `tick` after it. Counts and outputs change only on `tick`, or on a bus write to that counter.
- R7: In mode 0 the output drops low when the control byte is written and when a count is loaded. It rises when the count reaches 0, N+1 ticks after the last count byte is written. The counter then keeps decrementing, wrapping 0 to 16'hFFFF (binary) or 16'h9999 (BCD).
- R8: In mode 2 with count N the output is low for exactly one tick when the count reaches 1, and the period is N ticks.
- R9: In mode 3 with count N the output is high for ceil(N/2) ticks and low for floor(N/2) ticks.
- R10: A loaded count of 0 stands for 65536 in binary and 10000 in BCD.
- R11: In BCD, each decrement borrows across the four decimal digits, and mode 3 halves the BCD value digit by digit.
- R12: In modes 1, 4 and 5 the output stays high. A loaded count is taken but does not decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Common count enable for all counters |
| bus_addr | input | 2 | Register address: 0..2 count ports, 3 control |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data byte |
| bus_rd | input | 1 | Read strobe; advances the byte pointer and latch state |
| bus_rdata | output | 8 | Read data for the addressed count port (0 at address 3) |
| tmr_out | output | 3 | One output per counter |

## Verification
Mode 2 and mode 3 are run with small odd and even counts (5 and 6), with a BCD count (11) and with a count of 0 in both binaries. The measured low and high run lengths separate a correct halving rule from an off-by-one and binary halving from digit-wise halving. Mode 0 is run to terminal count and stepped one tick further with `tick` gated, which shows the exact rise cycle and the binary and BCD wrap values. Byte sequencing is tried with a partial write followed by a new control byte, which exposes a pointer that is not reset. A latch is followed by further ticks and a second latch command, which tells a held snapshot apart from a live read or a re-latch.

// File: rtl/timer_pkg.sv
package timer_pkg;

  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam logic [1:0] CTL_ADDR = 2'd3;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_BOTH  = 2'd3
  } acc_e;

  localparam logic [2:0] MODE_TERM   = 3'd0;
  localparam logic [2:0] MODE_RATE   = 3'd2;
  localparam logic [2:0] MODE_SQUARE = 3'd3;

endpackage

// File: rtl/timer_access.sv
module timer_access
  import timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_acc,
  input  logic              latch_cmd,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [BYTE_W-1:0] din,
  input  logic [CNT_W-1:0]  live_cnt,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              load_stb,
  output logic [CNT_W-1:0]  load_val
);

  acc_e              acc_q;
  logic              ptr_q;
  logic [BYTE_W-1:0] lo_q;
  logic [CNT_W-1:0]  lat_q;
  logic [1:0]        lat_left_q;

  logic              two_byte;
  logic              toggle;
  logic [CNT_W-1:0]  src;
  logic              sel_hi;

  assign two_byte = (acc_q == ACC_BOTH);
  assign toggle   = two_byte && (wr_stb || rd_stb);

  // a count write is complete on the single byte, or on the high byte of a pair
  assign load_stb = wr_stb && (!two_byte || ptr_q);

  always_comb begin
    case (acc_q)
      ACC_HI:   load_val = {din, {BYTE_W{1'b0}}};
      ACC_BOTH: load_val = {din, lo_q};
      default:  load_val = {{BYTE_W{1'b0}}, din};
    endcase
  end

  assign src     = (lat_left_q != 2'd0) ? lat_q : live_cnt;
  assign sel_hi  = (acc_q == ACC_HI) || (two_byte && ptr_q);
  assign rd_byte = sel_hi ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q      <= ACC_LO;
      ptr_q      <= 1'b0;
      lo_q       <= '0;
      lat_q      <= '0;
      lat_left_q <= 2'd0;
    end else if (cfg_wr) begin
      acc_q      <= acc_e'(cfg_acc);
      ptr_q      <= 1'b0;
      lat_left_q <= 2'd0;
    end else begin
      if (toggle) ptr_q <= ~ptr_q;
      if (wr_stb && two_byte && !ptr_q) lo_q <= din;
      if (latch_cmd && (lat_left_q == 2'd0)) begin
        lat_q      <= live_cnt;
        lat_left_q <= two_byte ? 2'd2 : 2'd1;
      end else if (rd_stb && (lat_left_q != 2'd0)) begin
        lat_left_q <= lat_left_q - 2'd1;
      end
    end
  end

endmodule

// File: rtl/timer_engine.sv
module timer_engine
  import timer_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cfg_wr,
  input  logic [2:0]    cfg_mode,
  input  logic          cfg_bcd,
  input  logic          load_stb,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] count_o,
  output logic [2:0]    mode_o,
  output logic          out_o
);

  localparam int DIG = CW / 4;

  logic [2:0]    mode_q;
  logic          bcd_q;
  logic [CW-1:0] reload_q;
  logic [CW-1:0] count_q;
  logic [CW-1:0] half_q;
  logic          pend_q;
  logic          run_q;
  logic          out_q;
  logic [CW-1:0] dec_val;

  function automatic logic [CW-1:0] step_down(input logic [CW-1:0] v, input logic bcd);
    logic [CW-1:0] r;
    logic          brw;
    logic [3:0]    nib;
    if (!bcd) begin
      r = v - CW'(1);
    end else begin
      r   = v;
      brw = 1'b1;
      for (int d = 0; d < DIG; d++) begin
        nib = v[d*4 +: 4];
        if (brw) begin
          if (nib == 4'd0) begin
            r[d*4 +: 4] = 4'd9;
          end else begin
            r[d*4 +: 4] = nib - 4'd1;
            brw = 1'b0;
          end
        end
      end
    end
    return r;
  endfunction

  // half of the loaded value, with 0 taken as the full range
  function automatic logic [CW-1:0] halve(input logic [CW-1:0] v, input logic bcd);
    logic [CW-1:0] r;
    logic          odd;
    logic [3:0]    nib;
    r = '0;
    if (v == '0) begin
      if (bcd) r[CW-1 -: 4] = 4'd5;
      else     r[CW-1]      = 1'b1;
    end else if (!bcd) begin
      r = v >> 1;
    end else begin
      odd = 1'b0;
      for (int d = DIG - 1; d >= 0; d--) begin
        nib = v[d*4 +: 4];
        r[d*4 +: 4] = {1'b0, nib[3:1]} + (odd ? 4'd5 : 4'd0);
        odd = nib[0];
      end
    end
    return r;
  endfunction

  function automatic logic above(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (a == '0) || (a > b);
  endfunction

  assign dec_val = step_down(count_q, bcd_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MODE_TERM;
      bcd_q    <= 1'b0;
      reload_q <= '0;
      count_q  <= '0;
      half_q   <= '0;
      pend_q   <= 1'b0;
      run_q    <= 1'b0;
      out_q    <= 1'b1;
    end else if (cfg_wr) begin
      mode_q <= cfg_mode;
      bcd_q  <= cfg_bcd;
      pend_q <= 1'b0;
      run_q  <= 1'b0;
      out_q  <= (cfg_mode != MODE_TERM);
    end else if (load_stb) begin
      reload_q <= load_val;
      half_q   <= halve(load_val, bcd_q);
      pend_q   <= 1'b1;
      if (mode_q == MODE_TERM) out_q <= 1'b0;
    end else if (tick) begin
      if (pend_q) begin
        count_q <= reload_q;
        pend_q  <= 1'b0;
        run_q   <= 1'b1;
        if (mode_q != MODE_TERM) out_q <= 1'b1;
      end else if (run_q) begin
        case (mode_q)
          MODE_TERM: begin
            count_q <= dec_val;
            if (count_q == CW'(1)) out_q <= 1'b1;
          end
          MODE_RATE: begin
            if (count_q == CW'(1)) begin
              count_q <= reload_q;
              out_q   <= 1'b1;
            end else begin
              count_q <= dec_val;
              out_q   <= (count_q != CW'(2));
            end
          end
          MODE_SQUARE: begin
            if (count_q == CW'(1)) begin
              count_q <= reload_q;
              out_q   <= above(reload_q, half_q);
            end else begin
              count_q <= dec_val;
              out_q   <= above(dec_val, half_q);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign count_o = count_q;
  assign mode_o  = mode_q;
  assign out_o   = out_q;

endmodule

// File: rtl/interval_timer_trio.sv
module interval_timer_trio
  import timer_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] tmr_out
);

  logic              ctl_wr;
  logic [1:0]        ctl_sel;
  logic [1:0]        ctl_acc;
  logic [2:0]        ctl_mode;
  logic              ctl_bcd;

  logic [NUM_CH-1:0][2:0]       ch_mode;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_count;
  logic [BYTE_W-1:0]            ch_rbyte [NUM_CH];

  assign ctl_wr  = bus_wr && (bus_addr == CTL_ADDR);
  assign ctl_sel = bus_wdata[7:6];
  assign ctl_acc = bus_wdata[5:4];
  assign ctl_bcd = bus_wdata[0];

  // codes 6 and 7 fold onto the rate and square modes
  always_comb begin
    ctl_mode = bus_wdata[3:1];
    if (ctl_mode[2] && ctl_mode[1]) ctl_mode = {1'b0, ctl_mode[1:0]};
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [1:0] IDX = 2'(i);
    logic hit;
    logic cfg_wr;
    logic latch_cmd;
    logic wr_stb;
    logic rd_stb;
    logic load_stb;
    logic [CNT_W-1:0] load_val;

    assign hit       = ctl_wr && (ctl_sel == IDX);
    assign cfg_wr    = hit && (ctl_acc != ACC_LATCH);
    assign latch_cmd = hit && (ctl_acc == ACC_LATCH);
    assign wr_stb    = bus_wr && (bus_addr == IDX);
    assign rd_stb    = bus_rd && (bus_addr == IDX);

    timer_access u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_acc   (ctl_acc),
      .latch_cmd (latch_cmd),
      .wr_stb    (wr_stb),
      .rd_stb    (rd_stb),
      .din       (bus_wdata),
      .live_cnt  (ch_count[i]),
      .rd_byte   (ch_rbyte[i]),
      .load_stb  (load_stb),
      .load_val  (load_val)
    );

    timer_engine #(.CW(CNT_W)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .cfg_wr   (cfg_wr),
      .cfg_mode (ctl_mode),
      .cfg_bcd  (ctl_bcd),
      .load_stb (load_stb),
      .load_val (load_val),
      .count_o  (ch_count[i]),
      .mode_o   (ch_mode[i]),
      .out_o    (tmr_out[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == 2'(i)) bus_rdata = ch_rbyte[i];
    end
  end

endmodule

// File: rtl/timer_checker.sv
module timer_checker
  import timer_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         tick,
  input logic [1:0]                   bus_addr,
  input logic                         bus_wr,
  input logic [BYTE_W-1:0]            bus_wdata,
  input logic [NUM_CH-1:0]            tmr_out,
  input logic [NUM_CH-1:0][2:0]       ch_mode,
  input logic [NUM_CH-1:0][CNT_W-1:0] ch_count
);

  // R2: a control byte whose select field is 3 leaves every mode alone
  a_r2_ignored_select: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CTL_ADDR && bus_wdata[7:6] == 2'd3) |=> $stable(ch_mode));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R6: without tick the count never moves
    a_r6_count_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(ch_count[i]));

    // R6: without tick or a bus write the output never moves
    a_r6_out_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !bus_wr) |=> $stable(tmr_out[i]));

    // R12: unimplemented modes keep the output high
    a_r12_idle_modes_high: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_mode[i] == 3'd1 || ch_mode[i] == 3'd4 || ch_mode[i] == 3'd5) |-> tmr_out[i]);

    // R8: the rate generator pulse lasts one tick
    a_r8_rate_pulse_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_mode[i] == MODE_RATE && !tmr_out[i] && tick && !bus_wr) |=> tmr_out[i]);

    // R7: in mode 0 the output only rises on a tick
    a_r7_term_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_mode[i] == MODE_TERM && $rose(tmr_out[i])) |-> $past(tick));
  end

endmodule

bind interval_timer_trio timer_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .tmr_out   (tmr_out),
  .ch_mode   (ch_mode),
  .ch_count  (ch_count)
);

// File: tb/tb_interval_timer_trio.sv
`timescale 1ns/1ps
module tb_interval_timer_trio;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [2:0] tmr_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  interval_timer_trio #(.NUM_CH(3)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .tmr_out   (tmr_out)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wait_level(input int ch, input logic v, input int lim);
    int k = 0;
    while (tmr_out[ch] != v && k < lim) begin k++; @(negedge clk); end
  endtask

  task automatic run_len(input int ch, input logic v, input int lim, output int n);
    n = 0;
    while (tmr_out[ch] == v && n < lim) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset;
    logic [7:0] b;
    chk("R1 outputs high after reset", int'(tmr_out), 7);
    rd(2'd0, b);
    chk("R1 counter 0 reads zero", int'(b), 8'h00);
  endtask

  task automatic t_access;
    logic [7:0] b;
    tick = 1'b1;
    wr(2'd3, 8'h12);                 // ch0, low only, mode 1
    chk("R12 mode 1 output high", int'(tmr_out[0]), 1);
    wr(2'd0, 8'h34);
    repeat (6) @(negedge clk);
    rd(2'd0, b);
    chk("R3 low-only load / R12 count holds", int'(b), 8'h34);
    chk("R12 output still high", int'(tmr_out[0]), 1);
    wr(2'd3, 8'h22);                 // ch0, high only, mode 1
    wr(2'd0, 8'hAB);
    repeat (2) @(negedge clk);
    rd(2'd0, b);
    chk("R3 high-only load", int'(b), 8'hAB);
    wr(2'd3, 8'h32);                 // ch0, low then high
    wr(2'd0, 8'hCD);                 // partial write, pointer now high
    wr(2'd3, 8'h32);                 // pointer back to low
    wr(2'd0, 8'h78);
    wr(2'd0, 8'h56);
    repeat (2) @(negedge clk);
    rd(2'd0, b);
    chk("R3 pair low byte after pointer reset", int'(b), 8'h78);
    rd(2'd0, b);
    chk("R3 pair high byte", int'(b), 8'h56);
    wr(2'd3, 8'hF0);                 // select field 3: ignored
    repeat (2) @(negedge clk);
    chk("R2 select 3 leaves ch0 output", int'(tmr_out[0]), 1);
    rd(2'd0, b);
    chk("R2 select 3 leaves ch0 low", int'(b), 8'h78);
    rd(2'd0, b);
    chk("R2 select 3 leaves ch0 high", int'(b), 8'h56);
  endtask

  task automatic t_load_latch;
    logic [7:0] lo, hi;
    tick = 1'b0;
    wr(2'd3, 8'h74);                 // ch1, pair, mode 2
    wr(2'd1, 8'h10);
    wr(2'd1, 8'h00);
    repeat (3) @(negedge clk);
    rd(2'd1, lo); rd(2'd1, hi);
    chk("R6 no load before tick", int'({hi, lo}), 0);
    ticks(1);
    rd(2'd1, lo); rd(2'd1, hi);
    chk("R6 loaded on first tick", int'({hi, lo}), 16);
    ticks(3);
    rd(2'd1, lo); rd(2'd1, hi);
    chk("R6 three ticks", int'({hi, lo}), 13);
    wr(2'd3, 8'h40);                 // latch ch1 at 13
    ticks(5);                        // live 8
    wr(2'd3, 8'h40);                 // ignored, snapshot unread
    rd(2'd1, lo); rd(2'd1, hi);
    chk("R4 snapshot held past ticks and second latch", int'({hi, lo}), 13);
    wr(2'd3, 8'h40);                 // new latch at 8
    ticks(2);                        // live 6
    rd(2'd1, lo); rd(2'd1, hi);
    chk("R4 new latch after full read", int'({hi, lo}), 8);
    rd(2'd1, lo); rd(2'd1, hi);
    chk("R5 live read after latch consumed", int'({hi, lo}), 6);
    ticks(1);
    rd(2'd1, lo); rd(2'd1, hi);
    chk("R5 reads did not disturb count", int'({hi, lo}), 5);
    tick = 1'b1;
  endtask

  task automatic t_rate;
    int n;
    tick = 1'b1;
    wr(2'd3, 8'h7C);                 // ch1, pair, code 6 -> mode 2
    wr(2'd1, 8'h05);
    wr(2'd1, 8'h00);
    wait_level(1, 1'b0, 100);
    run_len(1, 1'b0, 100, n);
    chk("R8 low for one tick (code 6 as mode 2, R2)", n, 1);
    run_len(1, 1'b1, 100, n);
    chk("R8 high for N-1 ticks", n, 4);
  endtask

  task automatic t_square(input logic [7:0] ctl, input logic [15:0] nval,
                          input int exp_lo, input int exp_hi, input string tag);
    int n;
    tick = 1'b1;
    wr(2'd3, ctl);
    wr(2'd2, nval[7:0]);
    wr(2'd2, nval[15:8]);
    wait_level(2, 1'b0, 70000);
    run_len(2, 1'b0, 70000, n);
    chk({tag, " low run"}, n, exp_lo);
    run_len(2, 1'b1, 70000, n);
    chk({tag, " high run"}, n, exp_hi);
  endtask

  task automatic t_term(input logic [7:0] ctl, input logic [7:0] nlo,
                        input int exp_low, input int exp_wrap, input string tag);
    int n;
    logic [7:0] lo, hi;
    tick = 1'b1;
    wr(2'd3, ctl);
    chk({tag, " low after control byte"}, int'(tmr_out[0]), 0);
    wr(2'd0, nlo);
    wr(2'd0, 8'h00);
    run_len(0, 1'b0, 100, n);
    tick = 1'b0;
    chk({tag, " low for N+1 samples"}, n, exp_low);
    chk({tag, " high at terminal count"}, int'(tmr_out[0]), 1);
    ticks(1);
    rd(2'd0, lo); rd(2'd0, hi);
    chk({tag, " wraps and keeps counting"}, int'({hi, lo}), exp_wrap);
    chk({tag, " stays high after wrap"}, int'(tmr_out[0]), 1);
    tick = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_access();
    t_load_latch();
    t_rate();
    t_square(8'hB6, 16'd5, 2, 3, "R9 N=5");
    t_square(8'hBE, 16'd6, 3, 3, "R9 N=6 code 7");
    t_square(8'hB7, 16'h0011, 5, 6, "R11 BCD 11 square");
    t_term(8'h30, 8'h04, 5, 16'hFFFF, "R7 binary");
    t_term(8'h31, 8'h02, 3, 16'h9999, "R11 BCD terminal");
    t_square(8'hB7, 16'h0000, 5000, 5000, "R10 BCD zero");
    t_square(8'hB6, 16'h0000, 32768, 32768, "R10 binary zero");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin cyc++; @(posedge clk); end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule